// File: doc/BRIEF.md
# Dual-Semantics State-Message Queue

This block is a small first-in first-out message channel with one producer and two consumer ports. Each port reads in its own way. The event port is a blocking reader: it raises a request and waits, and the transfer only happens once a message is on hand. The periodic port is a non-blocking reader that a time-scheduled consumer polls on its own timetable. It always gets a value in the same cycle.

When the periodic port finds a message waiting, it removes the head entry and also keeps a copy of it in a keeper register. When the queue is empty, the periodic port is served from the keeper, so a periodic consumer always sees the last state it received. The keeper is never loaded by event-port reads.

The queue refuses writes while it is full and records the refusal in a sticky flag. A write into an empty queue in the same cycle as an event request is handed straight to the event port.

Top module: `stmsg_queue`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0), `overflow`=0 and `keeperValid`=0. The keeper holds `KEEP_RESET`, which defaults to 0 and is what `ttData` shows for a periodic read of the empty queue.
- R2: Messages leave the queue in the order they were written, whichever port removes them.
- R3: While the queue is empty and `wrEn` is low, `evValid` stays 0 for as long as `evReq` is held, and no queue state changes.
- R4: A periodic read (`ttReq`=1) on a non-empty queue drives the head entry on `ttData` in the same cycle and sets `ttFresh`=1. It removes that entry at the next edge, copies it into the keeper and sets `keeperValid`=1.
- R5: A periodic read on an empty queue completes in the same cycle with `ttFresh`=0 and `ttData` equal to the keeper. The keeper and the queue stay unchanged.
- R6: A write while `full`=1 is refused and the stored entries are kept intact. It sets `overflow`, which stays 1 until reset.
- R7: When `ttReq` and `evReq` are both 1, the periodic port is served and `evValid` is 0. The event port gets the following entry on a later cycle.
- R8: With the queue empty, `wrEn`=1, `evReq`=1 and `ttReq`=0, `evValid` is 1 and `evData` equals `wrData` in that cycle. The message is not stored, so the queue stays empty.
- R9: `full` is 1 exactly when `DEPTH` entries are stored, and `empty` is 1 exactly when none are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe from the producer |
| wrData | input | DATA_W | Message to write |
| evReq | input | 1 | Event-port read request (ready), held until served |
| evValid | output | 1 | Event-port transfer happens this cycle |
| evData | output | DATA_W | Message for the event port, meaningful when evValid is 1 |
| ttReq | input | 1 | Periodic-port read, always completes this cycle |
| ttData | output | DATA_W | Head entry, or the keeper when the queue is empty |
| ttFresh | output | 1 | ttData is a newly removed entry rather than the keeper |
| keeperValid | output | 1 | At least one message has been loaded into the keeper |
| empty | output | 1 | No entries stored |
| full | output | 1 | DEPTH entries stored |
| overflow | output | 1 | Sticky: a write was refused because the queue was full |

## Verification
The assertions assume that `rstN` is held low for at least one clock edge before any request, and that `wrEn`, `evReq` and `ttReq` are known and steady around each rising edge. They also assume that `wrData` is known whenever `wrEn` is high. No other protocol is assumed: a full-queue write, simultaneous requests and an event request on an empty queue are all legal. The bench drives every input on the falling edge and holds it through the next rising edge. It keeps reset low for several cycles and always gives `wrData` a defined value.

// File: rtl/stmsg_pkg.sv
package stmsg_pkg;

  // Strobes from the control unit to the datapath, valid for one cycle.
  typedef struct packed {
    logic push;        // store wrData at the tail
    logic pop;         // drop the head entry
    logic keeperLoad;  // copy the head entry into the keeper
    logic qEmpty;      // no entries stored: steer outputs to bypass or keeper
  } qStrobe_t;

endpackage

// File: rtl/stmsg_ctrl.sv
module stmsg_ctrl
  import stmsg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  logic     evReq,
  input  logic     ttReq,
  output qStrobe_t strobe,
  output logic     evValid,
  output logic     ttFresh,
  output logic     keeperValid,
  output logic     empty,
  output logic     full,
  output logic     overflow
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic             bypass;
  logic             push;
  logic             pop;

  assign empty = (count == '0);
  assign full  = (count == CNT_FULL);

  // The periodic port wins any clash; the event port needs data or a bypass.
  assign ttFresh = ttReq && !empty;
  assign evValid = evReq && !ttReq && (!empty || wrEn);
  assign bypass  = evValid && empty;

  assign push = wrEn && !full && !bypass;
  assign pop  = ttFresh || (evValid && !empty);

  assign strobe.push       = push;
  assign strobe.pop        = pop;
  assign strobe.keeperLoad = ttFresh;
  assign strobe.qEmpty     = empty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count       <= '0;
      overflow    <= 1'b0;
      keeperValid <= 1'b0;
    end else begin
      count <= count + CNT_W'(push) - CNT_W'(pop);
      if (wrEn && full) overflow <= 1'b1;
      if (ttFresh) keeperValid <= 1'b1;
    end
  end

  // R9: the occupancy never goes past the depth
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_FULL);

  // R6: a full queue never takes a store
  assert_no_push_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strobe.push);

  // R6: the refusal flag is sticky
  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  // R6: a refused write while full and nothing leaving keeps the queue full
  assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (full && !strobe.pop) |=> full);

  // R3: an empty queue with no write leaves the event reader stalled
  assert_ev_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !wrEn && evReq) |=> empty);

  // R7: a periodic request leaves the event port waiting
  assert_tt_priority_R7: assert property (@(posedge clk) disable iff (!rstN)
    ttReq |-> !evValid);

  // R4: the keeper only becomes valid after a periodic read of real data
  assert_keeper_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keeperValid) |-> $past(ttReq && !empty));

endmodule

// File: rtl/stmsg_datapath.sv
module stmsg_datapath
  import stmsg_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              DEPTH      = 4,
  parameter logic [DATA_W-1:0] KEEP_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] evData,
  output logic [DATA_W-1:0] ttData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [DATA_W-1:0] headData;
  logic [DATA_W-1:0] keeper;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.push) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      keeper <= KEEP_RESET;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop) rdPtr <= nextPtr(rdPtr);
      if (strobe.keeperLoad) keeper <= headData;
    end
  end

  // Empty queue: the event port sees the bypassed write, the periodic port the keeper.
  assign evData = strobe.qEmpty ? wrData : headData;
  assign ttData = strobe.qEmpty ? keeper : headData;

  // R5: the keeper moves only on a periodic read of real data
  assert_keeper_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.keeperLoad |=> $stable(keeper));

  // R4: a keeper load captures the entry shown that cycle
  assert_keeper_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.keeperLoad |=> (keeper == $past(headData)));

  // R2: a pop always removes a stored entry, never a bypassed one
  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> !strobe.qEmpty);

endmodule

// File: rtl/stmsg_queue.sv
module stmsg_queue
  import stmsg_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter int                DEPTH      = 4,
  parameter logic [DATA_W-1:0] KEEP_RESET = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evReq,
  output logic              evValid,
  output logic [DATA_W-1:0] evData,
  input  logic              ttReq,
  output logic [DATA_W-1:0] ttData,
  output logic              ttFresh,
  output logic              keeperValid,
  output logic              empty,
  output logic              full,
  output logic              overflow
);

  qStrobe_t strobe;

  stmsg_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .evReq      (evReq),
    .ttReq      (ttReq),
    .strobe     (strobe),
    .evValid    (evValid),
    .ttFresh    (ttFresh),
    .keeperValid(keeperValid),
    .empty      (empty),
    .full       (full),
    .overflow   (overflow)
  );

  stmsg_datapath #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .KEEP_RESET(KEEP_RESET)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(wrData),
    .evData(evData),
    .ttData(ttData)
  );

endmodule

// File: tb/stmsg_queue_tb.sv
module stmsg_queue_tb_top;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              wrEn;
  logic [DATA_W-1:0] wrData;
  logic              evReq;
  logic              evValid;
  logic [DATA_W-1:0] evData;
  logic              ttReq;
  logic [DATA_W-1:0] ttData;
  logic              ttFresh;
  logic              keeperValid;
  logic              empty;
  logic              full;
  logic              overflow;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  stmsg_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .evReq(evReq), .evValid(evValid), .evData(evData),
    .ttReq(ttReq), .ttData(ttData), .ttFresh(ttFresh),
    .keeperValid(keeperValid), .empty(empty), .full(full), .overflow(overflow)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Inputs change on the falling edge; outputs are sampled 1 ns later.
  task automatic drive(input logic w, input logic [DATA_W-1:0] d, input logic e, input logic t);
    wrEn = w; wrData = d; evReq = e; ttReq = t;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic push(input logic [DATA_W-1:0] d);
    drive(1'b1, d, 1'b0, 1'b0);
    tick();
    idle();
  endtask

  task automatic t_reset();
    check("R1", "empty", int'(empty), 1);
    check("R1", "full", int'(full), 0);
    check("R1", "overflow", int'(overflow), 0);
    check("R1", "keeperValid", int'(keeperValid), 0);
    drive(1'b0, '0, 1'b0, 1'b1);
    check("R1", "ttData reset keeper", int'(ttData), 0);
    check("R5", "ttFresh empty", int'(ttFresh), 0);
    tick(); idle();
    check("R5", "still empty", int'(empty), 1);
    check("R5", "keeperValid stays 0", int'(keeperValid), 0);
  endtask

  task automatic t_order();
    push(8'd11); push(8'd22); push(8'd33);
    check("R9", "not empty", int'(empty), 0);
    drive(1'b0, '0, 1'b0, 1'b1);
    check("R4", "ttData head", int'(ttData), 11);
    check("R4", "ttFresh", int'(ttFresh), 1);
    tick(); idle();
    check("R4", "keeperValid set", int'(keeperValid), 1);
    drive(1'b0, '0, 1'b1, 1'b0);
    check("R2", "evValid", int'(evValid), 1);
    check("R2", "evData second", int'(evData), 22);
    tick(); idle();
    drive(1'b0, '0, 1'b0, 1'b1);
    check("R2", "ttData third", int'(ttData), 33);
    tick(); idle();
    check("R9", "empty after drain", int'(empty), 1);
  endtask

  task automatic t_tt_empty();
    for (int i = 0; i < 2; i++) begin
      drive(1'b0, '0, 1'b0, 1'b1);
      check("R5", "ttData keeper", int'(ttData), 33);
      check("R5", "ttFresh low", int'(ttFresh), 0);
      tick(); idle();
    end
    check("R5", "empty kept", int'(empty), 1);
  endtask

  task automatic t_ev_stall_bypass();
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 8'd99, 1'b1, 1'b0);
      check("R3", "evValid stalled", int'(evValid), 0);
      tick();
    end
    idle();
    check("R3", "empty after stall", int'(empty), 1);
    drive(1'b1, 8'd44, 1'b1, 1'b0);
    check("R8", "bypass evValid", int'(evValid), 1);
    check("R8", "bypass evData", int'(evData), 44);
    tick(); idle();
    check("R8", "queue stays empty", int'(empty), 1);
    drive(1'b0, '0, 1'b0, 1'b1);
    check("R5", "keeper untouched by event", int'(ttData), 33);
    tick(); idle();
  endtask

  task automatic t_full();
    for (int i = 1; i <= DEPTH; i++) push(DATA_W'(i));
    check("R9", "full", int'(full), 1);
    check("R6", "no overflow yet", int'(overflow), 0);
    push(8'd55);
    check("R6", "overflow set", int'(overflow), 1);
    check("R6", "still full", int'(full), 1);
    for (int i = 1; i <= DEPTH; i++) begin
      drive(1'b0, '0, 1'b1, 1'b0);
      check("R6", "entry intact", int'(evData), i);
      tick(); idle();
    end
    check("R9", "empty after drain", int'(empty), 1);
    check("R6", "overflow sticky", int'(overflow), 1);
  endtask

  task automatic t_priority();
    push(8'd7); push(8'd8);
    drive(1'b0, '0, 1'b1, 1'b1);
    check("R7", "event waits", int'(evValid), 0);
    check("R7", "tt served", int'(ttData), 7);
    tick(); idle();
    drive(1'b0, '0, 1'b1, 1'b0);
    check("R7", "event gets next", int'(evData), 8);
    check("R7", "event valid", int'(evValid), 1);
    tick(); idle();
    check("R7", "empty after", int'(empty), 1);
    drive(1'b0, '0, 1'b0, 1'b1);
    check("R4", "keeper from tt read", int'(ttData), 7);
    tick(); idle();
  endtask

  initial begin
    rstN = 1'b0;
    wrEn = 1'b0; wrData = '0; evReq = 1'b0; ttReq = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_order();
    t_tt_empty();
    t_ev_stall_bypass();
    t_full();
    t_priority();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule